// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is a 32-pin general-purpose I/O port with a per-pin interrupt detector. A simple register bus reaches it. Each pin has an output value, an output-enable flag and a synchronised input sample. Each pin can also raise interrupt status on a rising edge, a falling edge, a high level or a low level. All status bits are combined through a per-pin enable into one interrupt line.

Every register occupies a 16-byte slot with three write aliases. A write at slot offset 0x0 replaces the whole word. A write at 0x4 sets each bit written as 1. A write at 0x8 clears each bit written as 1. This lets software change single pins without a read-modify-write sequence. A pin raises status only when its routing bit admits it. The interrupt line is then gated a second time by an enable bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` is 0 and `irq_o` is low.
- R2: The register slot is `bus_addr_i[6:4]`: 0 output data, 1 input data, 2 output enable, 3 routing, 4 interrupt enable, 5 level select, 6 polarity, 7 status. The operation is `bus_addr_i[3:2]`: 0 writes the word, 1 ORs the data in, 2 clears the bits written as 1, and 3 does nothing. A write with `bus_addr_i[1:0]` or `bus_addr_i[7]` nonzero is ignored. Reads return the slot's word under any of its aliases.
- R3: `pin_o` equals the output-data register and `pin_oe_o` equals the output-enable register. An enable bit of 1 means the pin is driven.
- R4: The input-data slot returns `pin_i` two clock edges after it changes, whatever the output enable holds. Writes to that slot have no effect.
- R5: With level bit 0 and polarity bit 1, a 0-to-1 change on a routed pin sets its status bit.
- R6: With level bit 0 and polarity bit 0, a 1-to-0 change on a routed pin sets its status bit, and a 0-to-1 change does not.
- R7: With level bit 1, a routed pin sets its status bit while it is held high (polarity 1) or held low (polarity 0).
- R8: A pin whose routing bit is 0 never sets its status bit.
- R9: Status bits stay set until cleared through the bus. A level-mode bit whose condition still holds reads 1 again after a clear.
- R10: `irq_o` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R11: When a detected event and a bus clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address: slot and alias operation |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed slot |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Output values to the pads |
| pin_oe_o | output | 32 | Per-pin output drive enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet on one status bit in the same cycle: the detector setting it and a bus clear removing it. The bench provokes this by raising a pin configured for rising edges. It times the clear-alias write so that the write is sampled on the same edge that first sees the synchronised rise. The status bit must read 1 afterwards. A plain clear with no event must then read 0. The level-mode case is covered by a clear issued while the level condition holds, which must not empty the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        SLOT_DOUT   = 3'd0,
        SLOT_DIN    = 3'd1,
        SLOT_OE     = 3'd2,
        SLOT_ROUTE  = 3'd3,
        SLOT_IEN    = 3'd4,
        SLOT_LEVEL  = 3'd5,
        SLOT_POL    = 3'd6,
        SLOT_STATUS = 3'd7
    } reg_slot_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    localparam int SLOT_LSB = 4;
    localparam int OP_LSB   = 2;

    // Applies one alias operation to a register word.
    function automatic logic [31:0] apply_op(input logic [31:0] cur,
                                             input alias_op_e op,
                                             input logic [31:0] wdata);
        logic [31:0] res;
        case (op)
            OP_WRITE: res = wdata;
            OP_SET:   res = cur | wdata;
            OP_CLEAR: res = cur & ~wdata;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw_i;
        sync_d.sync = sync_q.meta;
        sync_d.prev = sync_q.sync;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign cur_o  = sync_q.sync;
    assign prev_o = sync_q.prev;

    // The value a detector sees is the pad level from two edges back (R4).
    assert_sync_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> cur_o == $past(sync_q.meta));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] event_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic hit_level;
        logic hit_edge;
        always_comb begin
            hit_level = pol_i[p] ? cur_i[p] : ~cur_i[p];
            hit_edge  = pol_i[p] ? (cur_i[p] & ~prev_i[p])
                                 : (~cur_i[p] & prev_i[p]);
            event_o[p] = level_i[p] ? hit_level : hit_edge;
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPINS-1:0]  bus_wdata_i,
    output logic [NPINS-1:0]  bus_rdata_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              irq_o
);
    localparam int SLOT_W = 3;
    localparam int OP_W   = 2;
    localparam int HI_LSB = SLOT_LSB + SLOT_W;

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] route;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] level;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] status;
    } port_t;

    port_t port_d, port_q;

    logic [NPINS-1:0] in_cur, in_prev, trig_evt, status_set;
    logic             addr_ok, wr_en;
    reg_slot_e        slot;
    alias_op_e        op;
    logic [31:0]      wdata_ext;

    gpio_pin_sync #(.WIDTH(NPINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (pin_i),
        .cur_o  (in_cur),
        .prev_o (in_prev)
    );

    gpio_trig_detect #(.WIDTH(NPINS)) u_detect (
        .cur_i   (in_cur),
        .prev_i  (in_prev),
        .level_i (port_q.level),
        .pol_i   (port_q.pol),
        .event_o (trig_evt)
    );

    assign slot       = reg_slot_e'(bus_addr_i[SLOT_LSB +: SLOT_W]);
    assign op         = alias_op_e'(bus_addr_i[OP_LSB +: OP_W]);
    assign addr_ok    = (bus_addr_i[OP_LSB-1:0] == '0) &&
                        (bus_addr_i[ADDR_W-1:HI_LSB] == '0);
    assign wr_en      = bus_wr_i && addr_ok;
    assign wdata_ext  = 32'(bus_wdata_i);
    assign status_set = trig_evt & port_q.route;

    function automatic logic [NPINS-1:0] upd(input logic [NPINS-1:0] cur,
                                             input reg_slot_e target);
        logic [NPINS-1:0] res;
        res = cur;
        if (wr_en && slot == target)
            res = NPINS'(apply_op(32'(cur), op, wdata_ext));
        return res;
    endfunction

    always_comb begin
        port_d        = port_q;
        port_d.dout   = upd(port_q.dout,  SLOT_DOUT);
        port_d.oe     = upd(port_q.oe,    SLOT_OE);
        port_d.route  = upd(port_q.route, SLOT_ROUTE);
        port_d.ien    = upd(port_q.ien,   SLOT_IEN);
        port_d.level  = upd(port_q.level, SLOT_LEVEL);
        port_d.pol    = upd(port_q.pol,   SLOT_POL);
        // Detected events are ORed in after the bus update: set beats clear.
        port_d.status = upd(port_q.status, SLOT_STATUS) | status_set;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) port_q <= '0;
        else         port_q <= port_d;
    end

    always_comb begin
        case (slot)
            SLOT_DOUT:   bus_rdata_o = port_q.dout;
            SLOT_DIN:    bus_rdata_o = in_cur;
            SLOT_OE:     bus_rdata_o = port_q.oe;
            SLOT_ROUTE:  bus_rdata_o = port_q.route;
            SLOT_IEN:    bus_rdata_o = port_q.ien;
            SLOT_LEVEL:  bus_rdata_o = port_q.level;
            SLOT_POL:    bus_rdata_o = port_q.pol;
            default:     bus_rdata_o = port_q.status;
        endcase
    end

    assign pin_o    = port_q.dout;
    assign pin_oe_o = port_q.oe;
    assign irq_o    = |(port_q.status & port_q.ien);

    // R9: without a bus write, no status bit ever falls.
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_wr_i |=> (($past(port_q.status) & ~port_q.status) == '0));

    // R8: a bit that rises without a bus write must have been routed.
    assert_route_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_wr_i |=> ((port_q.status & ~$past(port_q.status) & ~$past(port_q.route)) == '0));

    // R11: a routed detector event always lands, whatever the bus did.
    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_set != '0) |=> ((port_q.status & $past(status_set)) == $past(status_set)));

    // R10: the request line needs at least one enabled source.
    assert_irq_enabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (port_q.ien != '0 && port_q.status != '0));

endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] pout, poe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
        .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
    );

    localparam logic [2:0] S_DOUT = 3'd0, S_DIN = 3'd1, S_OE = 3'd2, S_ROUTE = 3'd3,
                           S_IEN = 3'd4, S_LVL = 3'd5, S_POL = 3'd6, S_STAT = 3'd7;
    localparam logic [1:0] O_WR = 2'd0, O_SET = 2'd1, O_CLR = 2'd2;

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] s, input logic [1:0] o, input logic [NP-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = {1'b0, s, o, 2'b00}; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] s, output logic [NP-1:0] v);
        @(negedge clk);
        addr = {1'b0, s, O_WR, 2'b00};
        #1 v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [NP-1:0] v;
        for (int s = 0; s < 8; s++) begin
            bus_read(3'(s), v);
            check("R1 register zero", v, '0);
        end
        check("R1 pin_oe", poe, '0);
        check("R1 irq", NP'(irq), '0);
    endtask

    task automatic t_alias();
        logic [NP-1:0] v;
        bus_write(S_DOUT, O_WR, 32'hF0F0_00FF);
        bus_write(S_DOUT, O_SET, 32'h0F00_0000);
        bus_read(S_DOUT, v);
        check("R2 set alias", v, 32'hFFF0_00FF);
        bus_write(S_DOUT, O_CLR, 32'h0000_000F);
        bus_read(S_DOUT, v);
        check("R2 clear alias", v, 32'hFFF0_00F0);
        bus_write(S_DOUT, 2'd3, 32'h0);
        bus_read(S_DOUT, v);
        check("R2 no-op alias", v, 32'hFFF0_00F0);
        @(negedge clk);
        wr = 1'b1; addr = 8'h01; wdata = '0;
        @(negedge clk);
        wr = 1'b0;
        bus_read(S_DOUT, v);
        check("R2 misaligned ignored", v, 32'hFFF0_00F0);
        check("R3 pin_o", pout, 32'hFFF0_00F0);
        bus_write(S_OE, O_SET, 32'h8000_0001);
        check("R3 pin_oe", poe, 32'h8000_0001);
    endtask

    task automatic t_din();
        logic [NP-1:0] v;
        @(negedge clk);
        pins = 32'hA5A5_5A5A;
        idle(3);
        bus_read(S_DIN, v);
        check("R4 input sample", v, 32'hA5A5_5A5A);
        bus_write(S_DIN, O_WR, 32'h0);
        bus_read(S_DIN, v);
        check("R4 din write ignored", v, 32'hA5A5_5A5A);
        @(negedge clk);
        pins = '0;
        idle(4);
        bus_write(S_OE, O_WR, '0);
    endtask

    task automatic t_rise();
        logic [NP-1:0] v;
        bus_write(S_STAT, O_CLR, '1);
        bus_write(S_POL, O_SET, 32'h1);
        bus_write(S_ROUTE, O_SET, 32'h1);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
        bus_read(S_STAT, v);
        check("R5 rising sets status", v & 32'h1, 32'h1);
        check("R10 irq masked", NP'(irq), '0);
        bus_write(S_IEN, O_SET, 32'h1);
        check("R10 irq raised", NP'(irq), 1);
        bus_write(S_STAT, O_CLR, 32'h1);
        bus_read(S_STAT, v);
        check("R9 edge bit cleared", v & 32'h1, 32'h0);
        check("R10 irq dropped", NP'(irq), '0);
    endtask

    task automatic t_fall();
        logic [NP-1:0] v;
        bus_write(S_ROUTE, O_SET, 32'h2);
        @(negedge clk); pins[1] = 1'b1;
        idle(4);
        bus_read(S_STAT, v);
        check("R6 rise ignored in falling mode", v & 32'h2, 32'h0);
        @(negedge clk); pins[1] = 1'b0;
        idle(4);
        bus_read(S_STAT, v);
        check("R6 falling sets status", v & 32'h2, 32'h2);
    endtask

    task automatic t_level();
        logic [NP-1:0] v;
        bus_write(S_LVL, O_SET, 32'hC);
        bus_write(S_POL, O_SET, 32'h4);
        bus_write(S_STAT, O_CLR, 32'hC);
        bus_write(S_ROUTE, O_SET, 32'hC);
        idle(2);
        bus_read(S_STAT, v);
        check("R7 low level sets status", v & 32'hC, 32'h8);
        @(negedge clk); pins[2] = 1'b1;
        idle(4);
        bus_read(S_STAT, v);
        check("R7 high level sets status", v & 32'h4, 32'h4);
        bus_write(S_STAT, O_CLR, 32'h4);
        bus_read(S_STAT, v);
        check("R9 level bit re-set while held", v & 32'h4, 32'h4);
        @(negedge clk); pins[2] = 1'b0;
        idle(4);
        bus_write(S_STAT, O_CLR, 32'h4);
        bus_read(S_STAT, v);
        check("R9 level bit clears once released", v & 32'h4, 32'h0);
        bus_write(S_ROUTE, O_CLR, 32'hC);
    endtask

    task automatic t_route();
        logic [NP-1:0] v;
        bus_write(S_STAT, O_CLR, '1);
        bus_write(S_POL, O_SET, 32'h10);
        bus_write(S_IEN, O_WR, '1);
        @(negedge clk); pins[4] = 1'b1;
        idle(4);
        bus_read(S_STAT, v);
        check("R8 unrouted pin no status", v & 32'h10, 32'h0);
        check("R8 unrouted pin no irq", NP'(irq), '0);
        bus_write(S_IEN, O_WR, '0);
    endtask

    task automatic t_race();
        logic [NP-1:0] v;
        bus_write(S_POL, O_SET, 32'h20);
        bus_write(S_ROUTE, O_SET, 32'h20);
        @(negedge clk); pins[5] = 1'b1;
        idle(4);
        @(negedge clk); pins[5] = 1'b0;
        idle(4);
        bus_read(S_STAT, v);
        check("R11 setup status held", v & 32'h20, 32'h20);
        @(negedge clk); pins[5] = 1'b1;
        @(negedge clk);
        bus_write(S_STAT, O_CLR, 32'h20);
        bus_read(S_STAT, v);
        check("R11 event beats clear", v & 32'h20, 32'h20);
        bus_write(S_STAT, O_CLR, 32'h20);
        bus_read(S_STAT, v);
        check("R11 plain clear", v & 32'h20, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_alias();
        t_din();
        t_rise();
        t_fall();
        t_level();
        t_route();
        t_race();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule